// File: doc/BRIEF.md
# Pixel Memory Rectangle Copy Engine

This engine moves a rectangle of 16-bit pixels from one place to another inside a frame store of 1024 columns by 512 rows. A host hands it a command of four 32-bit words, one per accepted cycle. The first word carries the operation code, and the next three give the source corner, the destination corner and the rectangle size. Once the last word is in, the engine walks the rectangle row by row through a single synchronous RAM port. It reads a run of up to 128 pixels into a local line buffer, then writes that run to the destination. An optional mask bit can be forced into bit 15 of every pixel it writes.

Source and destination coordinates wrap independently: columns wrap modulo 1024 and rows modulo 512. A copy onto itself with no mask has no effect, so the engine finishes such a command at once and never touches memory. When a copy does finish, a one-cycle completion pulse reports the destination rectangle, which a downstream cache can use to drop stale lines.

Top module: `vram_rect_copy`

## Requirements
- R1: A command is four accepted words. The first word is taken as a command only when bits 31:24 lie in 0x80..0x9F (bits 31:29 equal 3'b100). A first word outside that range is dropped, and the engine keeps waiting for a command word. The next three words are the source, the destination and the size, in that order.
- R2: Width is ((size[15:0] - 1) & 0x3FF) + 1 and height is ((size[31:16] - 1) & 0x1FF) + 1, so a zero field means 1024 columns or 512 rows. Exactly width*height pixel writes are made.
- R3: When the source equals the destination and the mask is 0, the done pulse rises at the clock edge that accepts the size word. No memory access is made and busy never rises.
- R4: Each row is handled in chunks of up to 128 pixels. Every pixel of a chunk is read before any pixel of that chunk is written, so an overlapping copy inside one chunk reads the original values.
- R5: In both words, X is bits 9:0 and Y is bits 24:16. Column addresses wrap modulo 1024 and row addresses wrap modulo 512. The memory address is row*1024 + column. Read data is due one cycle after mem_re.
- R6: Each written pixel is the source pixel ORed with set_mask in bit 15. set_mask is sampled when the size word is accepted.
- R7: Rows are processed in increasing order, and within a row the chunks go left to right.
- R8: cmd_ready is high only while idle. busy is high from the cycle after the size word is accepted through the last write, and the first read is issued in that cycle.
- R9: done is a one-cycle pulse in the cycle after the last write. While it is high, done_x, done_y, done_w and done_h give the destination corner and the decoded size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cmd_valid | input | 1 | command word present |
| cmd_data | input | 32 | command word |
| cmd_ready | output | 1 | word accepted when high with cmd_valid |
| set_mask | input | 1 | force bit 15 in written pixels |
| busy | output | 1 | copy in progress |
| mem_re | output | 1 | memory read strobe |
| mem_we | output | 1 | memory write strobe |
| mem_addr | output | 19 | row*1024 + column |
| mem_wdata | output | 16 | write pixel |
| mem_rdata | input | 16 | read pixel, one cycle after mem_re |
| done | output | 1 | completion pulse |
| done_x | output | 10 | destination column |
| done_y | output | 9 | destination row |
| done_w | output | 11 | copied width |
| done_h | output | 10 | copied height |

## Verification
The skip case has its done pulse due in the cycle right after the size word is accepted. For a real copy, the first read is due in that same following cycle, and done is due exactly one cycle after the last mem_we. The bench stamps every event with a cycle count taken on the rising edge and reads the stamps at the falling edge, then checks these distances exactly. Memory contents are compared only after done, against a chunked reference model applied to a shadow store, and the stray-write and count checks cover every address either store has touched.

// File: rtl/vram_rect_copy.sv
module vram_rect_copy #(
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int PW    = 16,
  parameter int CHUNK = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_data,
  output logic              cmd_ready,
  input  logic              set_mask,
  output logic              busy,
  output logic              mem_re,
  output logic              mem_we,
  output logic [XW+YW-1:0]  mem_addr,
  output logic [PW-1:0]     mem_wdata,
  input  logic [PW-1:0]     mem_rdata,
  output logic              done,
  output logic [XW-1:0]     done_x,
  output logic [YW-1:0]     done_y,
  output logic [XW:0]       done_w,
  output logic [YW:0]       done_h
);
  localparam int CW = $clog2(CHUNK);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_GAP, S_WR} st_t;
  st_t st;

  logic [1:0]    wcnt;
  logic [XW-1:0] sx, dx;
  logic [YW-1:0] sy, dy;
  logic [XW:0]   w_q, col;
  logic [YW:0]   h_q, row;
  logic          mask_q;
  logic [CW-1:0] idx, rd_idx;
  logic          rd_vld;
  logic [PW-1:0] lbuf [CHUNK];

  logic [XW:0]   rem, chunk_len;
  logic          last_idx, take;
  logic [XW-1:0] wm1;
  logic [YW-1:0] hm1;
  logic [XW-1:0] rcol, wcol;
  logic [YW-1:0] rrow, wrow;

  assign cmd_ready = (st == S_IDLE);
  assign busy      = (st != S_IDLE);
  assign take      = cmd_valid && cmd_ready;
  assign rem       = w_q - col;
  assign chunk_len = (rem > (XW+1)'(CHUNK)) ? (XW+1)'(CHUNK) : rem;
  assign last_idx  = ((XW+1)'(idx) == chunk_len - 1'b1);
  assign wm1       = cmd_data[XW-1:0] - 1'b1;
  assign hm1       = cmd_data[16 +: YW] - 1'b1;
  assign rcol      = sx + col[XW-1:0] + XW'(idx);
  assign wcol      = dx + col[XW-1:0] + XW'(idx);
  assign rrow      = sy + row[YW-1:0];
  assign wrow      = dy + row[YW-1:0];
  assign mem_re    = (st == S_RD);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = mem_we ? {wrow, wcol} : {rrow, rcol};
  assign mem_wdata = {lbuf[idx][PW-1] | mask_q, lbuf[idx][PW-2:0]};
  assign done_x    = dx;
  assign done_y    = dy;
  assign done_w    = w_q;
  assign done_h    = h_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wcnt   <= '0;
      sx     <= '0;
      sy     <= '0;
      dx     <= '0;
      dy     <= '0;
      w_q    <= '0;
      h_q    <= '0;
      mask_q <= 1'b0;
      row    <= '0;
      col    <= '0;
      idx    <= '0;
      done   <= 1'b0;
      rd_vld <= 1'b0;
      rd_idx <= '0;
    end else begin
      done   <= 1'b0;
      rd_vld <= (st == S_RD);
      rd_idx <= idx;
      case (st)
        S_IDLE: if (take) begin
          case (wcnt)
            2'd0: if (cmd_data[31:29] == 3'b100) wcnt <= 2'd1;
            2'd1: begin
              sx   <= cmd_data[XW-1:0];
              sy   <= cmd_data[16 +: YW];
              wcnt <= 2'd2;
            end
            2'd2: begin
              dx   <= cmd_data[XW-1:0];
              dy   <= cmd_data[16 +: YW];
              wcnt <= 2'd3;
            end
            default: begin
              wcnt   <= 2'd0;
              w_q    <= {1'b0, wm1} + 1'b1;
              h_q    <= {1'b0, hm1} + 1'b1;
              mask_q <= set_mask;
              row    <= '0;
              col    <= '0;
              idx    <= '0;
              if (sx == dx && sy == dy && !set_mask) done <= 1'b1;
              else st <= S_RD;
            end
          endcase
        end
        S_RD: begin
          if (last_idx) begin
            idx <= '0;
            st  <= S_GAP;
          end else idx <= idx + 1'b1;
        end
        S_GAP: st <= S_WR;
        S_WR: begin
          if (last_idx) begin
            idx <= '0;
            if (col + chunk_len >= w_q) begin
              col <= '0;
              if (row == h_q - 1'b1) begin
                st   <= S_IDLE;
                done <= 1'b1;
              end else begin
                row <= row + 1'b1;
                st  <= S_RD;
              end
            end else begin
              col <= col + chunk_len;
              st  <= S_RD;
            end
          end else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rd_vld) lbuf[rd_idx] <= mem_rdata;
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_re && !mem_we));
  p_no_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_gap_before_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> !mem_re);
  p_mask_forced_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mask_q) |-> mem_wdata[PW-1]);
endmodule

// File: tb/vram_rect_copy_test.sv
module vram_rect_copy_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready;
  logic        set_mask = 1'b0;
  logic        busy, mem_re, mem_we, done;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [9:0]  done_x;
  logic [8:0]  done_y;
  logic [10:0] done_w;
  logic [9:0]  done_h;

  int total = 0, bad = 0;
  int cyc = 0;
  int wr_cnt, done_cnt, re_cnt, last_wr, done_cyc, first_re;
  logic [9:0]  dn_x;
  logic [8:0]  dn_y;
  logic [10:0] dn_w;
  logic [9:0]  dn_h;
  logic [15:0] dmem [int];
  logic [15:0] rmem [int];

  always #5 clk = ~clk;

  vram_rect_copy uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .set_mask(set_mask), .busy(busy),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done),
    .done_x(done_x), .done_y(done_y), .done_w(done_w), .done_h(done_h));

  function automatic logic [15:0] init_px(int a);
    int v;
    v = a * 40503 + (a >> 5) * 97 + 13;
    return v[15:0];
  endfunction

  function automatic logic [15:0] dget(int a);
    return dmem.exists(a) ? dmem[a] : init_px(a);
  endfunction

  function automatic logic [15:0] rget(int a);
    return rmem.exists(a) ? rmem[a] : init_px(a);
  endfunction

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= dget(int'(mem_addr));
    if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
    cyc = cyc + 1;
  end

  always @(negedge clk) begin
    if (mem_we) begin
      wr_cnt = wr_cnt + 1;
      last_wr = cyc;
    end
    if (mem_re) begin
      if (re_cnt == 0) first_re = cyc;
      re_cnt = re_cnt + 1;
    end
    if (done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
      dn_x = done_x; dn_y = done_y; dn_w = done_w; dn_h = done_h;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // chunked reference copy over the shadow store
  task automatic ref_copy(int sx, int sy, int dx, int dy, int w, int h, bit m);
    logic [15:0] lb [128];
    if (sx == dx && sy == dy && !m) return;
    for (int y = 0; y < h; y++) begin
      for (int x0 = 0; x0 < w; x0 += 128) begin
        int n;
        n = (w - x0 > 128) ? 128 : w - x0;
        for (int i = 0; i < n; i++)
          lb[i] = rget((((sy + y) & 511) << 10) | ((sx + x0 + i) & 1023));
        for (int i = 0; i < n; i++)
          rmem[(((dy + y) & 511) << 10) | ((dx + x0 + i) & 1023)] = lb[i] | {m, 15'd0};
      end
    end
  endtask

  task automatic send_word(logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_copy(logic [31:0] op, int sx, int sy, int dx, int dy,
                          logic [31:0] size, bit m, string req);
    int w, h, acc, waited, mism, exp_wr;
    bit skip;
    w = ((int'(size[15:0]) - 1) & 1023) + 1;
    h = ((int'(size[31:16]) - 1) & 511) + 1;
    skip = (sx == dx && sy == dy && !m);
    exp_wr = skip ? 0 : w * h;
    ref_copy(sx, sy, dx, dy, w, h, m);
    wr_cnt = 0; done_cnt = 0; re_cnt = 0; last_wr = -1; done_cyc = -1; first_re = -1;
    send_word(op);
    send_word({7'd0, 9'(sy), 6'd0, 10'(sx)});
    send_word({7'd0, 9'(dy), 6'd0, 10'(dx)});
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data = size;
    set_mask = m;
    acc = cyc;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    set_mask = 1'b0;
    if (!skip)
      check(busy && !cmd_ready, "R8", "busy/ready after accept", {busy, cmd_ready}, 2);
    waited = 0;
    while (done_cnt == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    check(wr_cnt == exp_wr, skip ? "R3" : "R2", "write count", wr_cnt, exp_wr);
    if (skip) begin
      check(done_cyc == acc + 1, "R3", "skip done cycle", done_cyc - acc, 1);
      check(re_cnt == 0, "R3", "skip read count", re_cnt, 0);
    end else begin
      check(done_cyc == last_wr + 1, "R9", "done after last write", done_cyc - last_wr, 1);
      check(first_re == acc + 1, "R8", "first read cycle", first_re - acc, 1);
    end
    check(dn_x == 10'(dx) && dn_y == 9'(dy), "R9", "done corner", {dn_y, dn_x}, (dy << 10) | dx);
    check(dn_w == 11'(w) && dn_h == 10'(h), "R2", "done size", {dn_h, dn_w}, (h << 11) | w);
    mism = 0;
    foreach (dmem[k]) if (dmem[k] !== rget(k)) mism++;
    foreach (rmem[k]) if (rmem[k] !== dget(k)) mism++;
    check(mism == 0, req, "memory mismatches", mism, 0);
  endtask

  initial begin
    #(200000 * 10);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    check(!busy && cmd_ready && !done && !mem_we && !mem_re, "R8", "reset state",
          {busy, cmd_ready, done, mem_we, mem_re}, 8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: foreign opcodes are dropped
    send_word(32'h7F00_0000);
    send_word(32'hA000_0000);
    @(negedge clk);
    check(!busy && cmd_ready && done_cnt == 0, "R1", "junk word ignored", {busy, cmd_ready}, 1);
    run_copy(32'h9F12_3456, 5, 6, 40, 41, 32'h0003_0010, 1'b0, "R1");

    run_copy(32'h8000_0000, 300, 100, 300, 100, 32'h0004_0020, 1'b0, "R3");
    run_copy(32'h8000_0000, 300, 100, 300, 100, 32'h0002_0009, 1'b1, "R6");
    run_copy(32'h8000_0000, 100, 20, 103, 20, 32'h0002_0032, 1'b0, "R4");
    run_copy(32'h8000_0000, 200, 30, 210, 30, 32'h0001_012C, 1'b0, "R4");
    run_copy(32'h8000_0000, 1000, 7, 5, 8, 32'h0002_003C, 1'b0, "R5");
    run_copy(32'h8000_0000, 12, 510, 40, 2, 32'h0005_0006, 1'b1, "R5");
    run_copy(32'h8000_0000, 20, 10, 20, 11, 32'h0004_0008, 1'b0, "R7");
    run_copy(32'h8000_0000, 0, 50, 0, 51, 32'h0001_0000, 1'b0, "R2");
    run_copy(32'h8000_0000, 700, 0, 3, 100, 32'h0000_0003, 1'b0, "R2");
    run_copy(32'h8000_0000, 9, 9, 60, 60, 32'hFE01_0402, 1'b0, "R2");

    for (int t = 0; t < 12; t++) begin
      int sx, sy, dx, dy, w, h;
      bit m;
      sx = $urandom % 1024; sy = $urandom % 512;
      dx = ($urandom % 4 == 0) ? (sx + $urandom % 40) % 1024 : $urandom % 1024;
      dy = ($urandom % 4 == 0) ? sy : $urandom % 512;
      w = 1 + $urandom % 300; h = 1 + $urandom % 5;
      m = ($urandom % 4 == 0);
      run_copy(32'h8000_0000 | ($urandom % 32) << 24, sx, sy, dx, dy,
               {16'(h), 16'(w)}, m, "R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule